// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (clock and open-drain data) sitting in front of a 128-byte, 8-bit-wide storage array. It watches the bus for START and STOP conditions, answers only to one fixed seven-bit device identity, and acknowledges each byte it accepts by holding the data line low through the ninth clock. A master can write one byte or a burst of up to eight, read sequentially from any address, or read from wherever the previous access left the internal address counter.

Write data is not stored straight into the array. Each accepted data byte goes into a page latch of eight slots that covers one aligned eight-byte page. When the master sends STOP, the latched bytes are committed together and a self-timed write cycle starts. The cycle length is a parameter counted in system clocks. While that cycle runs, the slave stays silent. A separate level input, taken from the pin that clocks the stream mode elsewhere in the chip, decides whether data bytes may be latched at all. A one-cycle pulse tells the surrounding mode controller that a control byte with a matching identity was accepted.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: A control byte is acknowledged only when its upper seven bits equal 1010000 and no write cycle is running. Each acknowledged control byte raises `ctrl_hit_o` for exactly one clock, while the data line is held low. Any other identity gets no acknowledge.
- R2: In a write the byte after the control byte (last bit 0) is the word address, of which only the low seven bits count. Every following data byte is acknowledged.
- R3: Data bytes land in the aligned eight-byte page chosen by address bits 6:3. The in-page offset (bits 2:0) steps by one per byte and wraps from 7 to 0, so later bytes overwrite earlier slots.
- R4: The array does not change until STOP. A repeated START throws away any latched bytes. A STOP with at least one latched byte commits them all and starts a write cycle of WRITE_CYCLES clocks.
- R5: While the write cycle runs, control bytes for both read and write are not acknowledged. Once it ends they are acknowledged again.
- R6: A data byte that arrives while `wr_allow_i` is low is still acknowledged but is not latched, so the array keeps its old value at that address.
- R7: A read (control byte last bit 1) returns the byte at the current address, most significant bit first. The address then increments, wrapping from 0x7F to 0x00. After the master's not-acknowledge the slave releases the data line.
- R8: After a read ends, a new read with no address phase continues from the address that follows the last byte returned.
- R9: The slave changes its data-line drive only while the bus clock is low.
- R10: After reset the data line is released, `ctrl_hit_o` is low, every array byte is zero and the current address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the master |
| sda_i | input | 1 | Resolved bus data level |
| wr_allow_i | input | 1 | High permits data bytes to be latched for writing |
| sda_low_o | output | 1 | High pulls the open-drain data line low |
| ctrl_hit_o | output | 1 | One-clock pulse when a matching control byte is acknowledged |

## Verification
A wrong internal state shows up on the data line within one byte time. A bad phase or bit count moves the acknowledge out of the ninth clock, or puts read data out of place on the next read. A bad page offset or commit condition shows only when the affected page is read back after the write cycle. A stuck busy timer shows as a control byte left unacknowledged for longer than WRITE_CYCLES clocks. A full sweep of all 128 device identities and sequential read-backs of specific pages turn each of these faults into a byte or acknowledge mismatch.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CTRL,
      PH_WADDR,
      PH_WDATA,
      PH_READ,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_bit,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_q, scl_qq, sda_q, sda_qq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q  <= 1'b1;
         scl_qq <= 1'b1;
         sda_q  <= 1'b1;
         sda_qq <= 1'b1;
      end else begin
         scl_q  <= scl_i;
         scl_qq <= scl_q;
         sda_q  <= sda_i;
         sda_qq <= sda_q;
      end
   end

   assign sda_bit   = sda_q;
   assign scl_rise  = scl_q & ~scl_qq;
   assign scl_fall  = ~scl_q & scl_qq;
   assign bus_start = scl_q & scl_qq & sda_qq & ~sda_q;
   assign bus_stop  = scl_q & scl_qq & ~sda_qq & sda_q;
endmodule

// File: rtl/eep_bus_fsm.sv
module eep_bus_fsm
   import eep_pkg::*;
#(
   parameter int         ADDR_W     = 7,
   parameter int         DATA_W     = 8,
   parameter int         PAGE_BYTES = 8,
   parameter logic [6:0] DEV_ID     = 7'b1010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              sda_bit,
   input  logic              busy_i,
   input  logic              wr_allow_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              sda_low_o,
   output logic              ctrl_hit_o,
   output logic              lat_clear_o,
   output logic              push_o,
   output logic [ADDR_W-1:0] push_addr_o,
   output logic [DATA_W-1:0] push_data_o,
   output logic              commit_req_o
);
   localparam int         PW    = $clog2(PAGE_BYTES);
   localparam logic [3:0] LAST  = 4'(DATA_W);
   localparam logic [3:0] ACKB  = 4'(DATA_W + 1);

   phase_e            phase;
   logic [3:0]        bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [ADDR_W-1:0] addr;
   logic              rd_mode;
   logic              m_ack;

   assign rd_addr_o = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_IDLE;
         bit_cnt      <= '0;
         shreg        <= '0;
         addr         <= '0;
         rd_mode      <= 1'b0;
         m_ack        <= 1'b0;
         sda_low_o    <= 1'b0;
         ctrl_hit_o   <= 1'b0;
         lat_clear_o  <= 1'b0;
         push_o       <= 1'b0;
         push_addr_o  <= '0;
         push_data_o  <= '0;
         commit_req_o <= 1'b0;
      end else begin
         ctrl_hit_o   <= 1'b0;
         lat_clear_o  <= 1'b0;
         push_o       <= 1'b0;
         commit_req_o <= 1'b0;
         if (bus_start) begin
            phase       <= PH_CTRL;
            bit_cnt     <= '0;
            sda_low_o   <= 1'b0;
            lat_clear_o <= 1'b1;
         end else if (bus_stop) begin
            phase        <= PH_IDLE;
            bit_cnt      <= '0;
            sda_low_o    <= 1'b0;
            commit_req_o <= 1'b1;
         end else if (scl_rise) begin
            case (phase)
               PH_CTRL, PH_WADDR, PH_WDATA: begin
                  if (bit_cnt < LAST) shreg <= {shreg[DATA_W-2:0], sda_bit};
                  bit_cnt <= bit_cnt + 4'd1;
               end
               PH_READ: begin
                  if (bit_cnt == LAST) m_ack <= ~sda_bit;
                  bit_cnt <= bit_cnt + 4'd1;
               end
               default: ;
            endcase
         end else if (scl_fall) begin
            case (phase)
               PH_CTRL, PH_WADDR, PH_WDATA: begin
                  if (bit_cnt == LAST) begin
                     if (phase == PH_CTRL) begin
                        if (shreg[DATA_W-1:1] == DEV_ID && !busy_i) begin
                           sda_low_o  <= 1'b1;
                           ctrl_hit_o <= 1'b1;
                           rd_mode    <= shreg[0];
                        end else begin
                           phase <= PH_SKIP;
                        end
                     end else if (phase == PH_WADDR) begin
                        addr      <= shreg[ADDR_W-1:0];
                        sda_low_o <= 1'b1;
                     end else begin
                        sda_low_o <= 1'b1;
                        if (wr_allow_i) begin
                           push_o      <= 1'b1;
                           push_addr_o <= addr;
                           push_data_o <= shreg;
                        end
                        addr <= {addr[ADDR_W-1:PW], addr[PW-1:0] + PW'(1)};
                     end
                  end else if (bit_cnt == ACKB) begin
                     bit_cnt   <= '0;
                     sda_low_o <= 1'b0;
                     if (phase == PH_CTRL) begin
                        if (rd_mode) begin
                           phase     <= PH_READ;
                           shreg     <= rd_data_i;
                           sda_low_o <= ~rd_data_i[DATA_W-1];
                           addr      <= addr + ADDR_W'(1);
                        end else begin
                           phase <= PH_WADDR;
                        end
                     end else if (phase == PH_WADDR) begin
                        phase <= PH_WDATA;
                     end
                  end
               end
               PH_READ: begin
                  if (bit_cnt >= 4'd1 && bit_cnt < LAST) begin
                     shreg     <= {shreg[DATA_W-2:0], 1'b0};
                     sda_low_o <= ~shreg[DATA_W-2];
                  end else if (bit_cnt == LAST) begin
                     sda_low_o <= 1'b0;
                  end else if (bit_cnt == ACKB) begin
                     bit_cnt <= '0;
                     if (m_ack) begin
                        shreg     <= rd_data_i;
                        sda_low_o <= ~rd_data_i[DATA_W-1];
                        addr      <= addr + ADDR_W'(1);
                     end else begin
                        sda_low_o <= 1'b0;
                        phase     <= PH_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clear_i,
   input  logic                                push_i,
   input  logic [ADDR_W-1:0]                   push_addr_i,
   input  logic [DATA_W-1:0]                   push_data_i,
   input  logic                                commit_req_i,
   output logic                                commit_o,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] base_o,
   output logic [PAGE_BYTES-1:0][DATA_W-1:0]   data_o,
   output logic [PAGE_BYTES-1:0]               valid_o
);
   localparam int PW = $clog2(PAGE_BYTES);

   assign commit_o = commit_req_i & (|valid_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      base_o <= '0;
      else if (push_i) base_o <= push_addr_i[ADDR_W-1:PW];
   end

   for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o[s] <= 1'b0;
            data_o[s]  <= '0;
         end else if (clear_i || commit_o) begin
            valid_o[s] <= 1'b0;
         end else if (push_i && push_addr_i[PW-1:0] == PW'(s)) begin
            valid_o[s] <= 1'b1;
            data_o[s]  <= push_data_i;
         end
      end
   end
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 8,
   parameter int WRITE_CYCLES = 1000
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 commit_i,
   input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] base_i,
   input  logic [PAGE_BYTES-1:0][DATA_W-1:0]    data_i,
   input  logic [PAGE_BYTES-1:0]                valid_i,
   input  logic [ADDR_W-1:0]                    rd_addr_i,
   output logic [DATA_W-1:0]                    rd_data_o,
   output logic                                 busy_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = $clog2(PAGE_BYTES);
   localparam int TW    = $clog2(WRITE_CYCLES + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [TW-1:0]     timer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (commit_i) begin
         for (int s = 0; s < PAGE_BYTES; s++)
            if (valid_i[s]) mem[{base_i, PW'(s)}] <= data_i[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            timer <= '0;
      else if (commit_i)     timer <= TW'(WRITE_CYCLES);
      else if (timer != '0)  timer <= timer - TW'(1);
   end

   assign busy_o    = (timer != '0);
   assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave #(
   parameter int         ADDR_W       = 7,
   parameter int         DATA_W       = 8,
   parameter int         PAGE_BYTES   = 8,
   parameter logic [6:0] DEV_ID       = 7'b1010000,
   parameter int         WRITE_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wr_allow_i,
   output logic sda_low_o,
   output logic ctrl_hit_o
);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int BW = ADDR_W - PW;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("DATA_W must be 8 for the byte-oriented bus");
   end
   if (ADDR_W < 2 || ADDR_W > 7) begin : g_bad_addr_w
      $error("ADDR_W must lie in 2..7");
   end
   if (PAGE_BYTES < 2 || (1 << PW) != PAGE_BYTES || PW >= ADDR_W) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two smaller than the array");
   end
   if (WRITE_CYCLES < 1) begin : g_bad_cycles
      $error("WRITE_CYCLES must be at least 1");
   end

   logic sda_bit, scl_rise, scl_fall, bus_start, bus_stop;
   logic busy, commit, lat_clear, push, commit_req;
   logic [ADDR_W-1:0] rd_addr, push_addr;
   logic [DATA_W-1:0] rd_data, push_data;
   logic [BW-1:0]     page_base;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data;
   logic [PAGE_BYTES-1:0]             page_valid;

   eep_line_sense u_sense (
      .clk, .rst_n, .scl_i, .sda_i,
      .sda_bit, .scl_rise, .scl_fall, .bus_start, .bus_stop
   );

   eep_bus_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .DEV_ID(DEV_ID)
   ) u_fsm (
      .clk, .rst_n, .scl_rise, .scl_fall, .bus_start, .bus_stop, .sda_bit,
      .busy_i(busy), .wr_allow_i, .rd_data_i(rd_data), .rd_addr_o(rd_addr),
      .sda_low_o, .ctrl_hit_o, .lat_clear_o(lat_clear), .push_o(push),
      .push_addr_o(push_addr), .push_data_o(push_data), .commit_req_o(commit_req)
   );

   eep_page_latch #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_latch (
      .clk, .rst_n, .clear_i(lat_clear), .push_i(push), .push_addr_i(push_addr),
      .push_data_i(push_data), .commit_req_i(commit_req), .commit_o(commit),
      .base_o(page_base), .data_o(page_data), .valid_o(page_valid)
   );

   eep_cell_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
      .WRITE_CYCLES(WRITE_CYCLES)
   ) u_array (
      .clk, .rst_n, .commit_i(commit), .base_i(page_base), .data_i(page_data),
      .valid_i(page_valid), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy)
   );
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_low,
   input logic ctrl_hit,
   input logic busy,
   input logic commit
);
   // R1: an accepted control byte is acknowledged in the same cycle
   assert_hit_acks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |-> sda_low);

   // R1: the match report lasts one clock only
   assert_hit_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> !ctrl_hit);

   // R5: no control byte is accepted during the write cycle
   assert_busy_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ctrl_hit);

   // R4: a write cycle only begins right after a commit
   assert_busy_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit));

   // R9: drive is steady while the bus clock stays high
   assert_sda_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_i, 2) && $past(scl_i) && scl_i) |-> $stable(sda_low));
endmodule

bind twowire_eeprom_slave eep_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_low(sda_low_o),
   .ctrl_hit(ctrl_hit_o), .busy(busy), .commit(commit)
);

// File: tb/tb_twowire_eeprom_slave.sv
module tb_twowire_eeprom_slave;
   localparam int WCYC = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic msda = 1'b1;
   logic wr_allow = 1'b1;
   logic sda_low, ctrl_hit;
   logic sda_i;

   int n_chk = 0;
   int n_err = 0;
   int hits = 0;
   int viol = 0;
   bit done = 1'b0;
   logic [7:0] model [128];
   logic scl_h1 = 1'b1, scl_h2 = 1'b1, low_h1 = 1'b0;

   always #4 clk = ~clk;
   assign sda_i = msda & ~sda_low;

   twowire_eeprom_slave #(.WRITE_CYCLES(WCYC)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_i),
      .wr_allow_i(wr_allow), .sda_low_o(sda_low), .ctrl_hit_o(ctrl_hit)
   );

   always @(posedge clk) begin
      if (rst_n && ctrl_hit) hits <= hits + 1;
      if (rst_n && scl_h2 && scl_h1 && scl && sda_low !== low_h1) viol <= viol + 1;
      scl_h2 <= scl_h1;
      scl_h1 <= scl;
      low_h1 <= sda_low;
   end

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      msda = 1'b1; half(); scl = 1'b1; half(); msda = 1'b0; half(); scl = 1'b0; half();
   endtask

   task automatic bus_stop();
      msda = 1'b0; half(); scl = 1'b1; half(); msda = 1'b1; half();
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         msda = b[i]; half(); scl = 1'b1; half(); scl = 1'b0; half();
      end
      msda = 1'b1; half(); scl = 1'b1; half();
      ack = (sda_i == 1'b0);
      scl = 1'b0; half();
   endtask

   task automatic read_byte(output logic [7:0] b, input bit give_ack);
      for (int i = 7; i >= 0; i--) begin
         msda = 1'b1; half(); scl = 1'b1; half();
         b[i] = sda_i;
         scl = 1'b0; half();
      end
      msda = ~give_ack; half(); scl = 1'b1; half(); scl = 1'b0; half();
      msda = 1'b1;
   endtask

   // Leaves the bus after an acknowledged write control byte
   task automatic poll_ready();
      bit ack = 1'b0;
      for (int t = 0; t < 400 && !ack; t++) begin
         bus_start();
         write_byte(8'hA0, ack);
         if (!ack) bus_stop();
      end
      chk("R5 ready after write cycle", int'(ack), 1);
   endtask

   task automatic page_write(input logic [6:0] a, input int n, input int seed);
      bit ack;
      logic [2:0] off;
      poll_ready();
      write_byte({1'b0, a}, ack);
      chk("R2 word address ack", int'(ack), 1);
      off = a[2:0];
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = 8'((seed + k * 29) & 255);
         write_byte(d, ack);
         chk("R2 data ack", int'(ack), 1);
         if (wr_allow) model[{a[6:3], off}] = d;
         off = off + 3'd1;
      end
      bus_stop();
   endtask

   task automatic read_back(input logic [6:0] a, input int n, input string req);
      bit ack;
      logic [7:0] b;
      logic [6:0] p;
      poll_ready();
      write_byte({1'b0, a}, ack);
      bus_start();
      write_byte(8'hA1, ack);
      chk(req, int'(ack), 1);
      p = a;
      for (int k = 0; k < n; k++) begin
         read_byte(b, k != n - 1);
         chk(req, int'(b), int'(model[p]));
         p = p + 7'd1;
      end
      chk("R7 line released after nack", int'(sda_low), 0);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         report();
      end
   end

   initial begin
      bit ack;
      logic [7:0] b;
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      half();
      // R10 reset state
      chk("R10 data released", int'(sda_low), 0);
      chk("R10 no hit", int'(ctrl_hit), 0);
      bus_start();
      write_byte(8'hA1, ack);
      chk("R10 read ack", int'(ack), 1);
      for (int k = 0; k < 3; k++) begin
         read_byte(b, k != 2);
         chk("R10 array zero from address 0", int'(b), 0);
      end
      bus_stop();

      // R1 sweep over every device identity
      hits = 0;
      for (int a = 0; a < 128; a++) begin
         bus_start();
         write_byte({7'(a), 1'b0}, ack);
         chk("R1 identity match", int'(ack), int'(a == 7'h50));
         bus_stop();
      end
      half();
      chk("R1 hit pulse count", hits, 1);

      // R2/R4 full page then R5 busy
      page_write(7'h10, 8, 5);
      bus_start();
      write_byte(8'hA0, ack);
      chk("R5 write control ignored while busy", int'(ack), 0);
      bus_stop();
      bus_start();
      write_byte(8'hA1, ack);
      chk("R5 read control ignored while busy", int'(ack), 0);
      bus_stop();
      read_back(7'h10, 8, "R4 page committed");

      // R3 offset wrap within page
      page_write(7'h26, 10, 77);
      read_back(7'h20, 9, "R3 in-page wrap");

      // R6 disabled writes
      wr_allow = 1'b0;
      page_write(7'h10, 3, 200);
      wr_allow = 1'b1;
      read_back(7'h10, 3, "R6 array unchanged");

      // R4 repeated START discards latched data
      poll_ready();
      write_byte(8'h30, ack);
      write_byte(8'h5A, ack);
      bus_start();
      write_byte(8'hA1, ack);
      read_byte(b, 1'b0);
      chk("R4 array unchanged before stop", int'(b), int'(model[7'h31]));
      bus_stop();
      bus_start();
      write_byte(8'hA0, ack);
      chk("R4 no commit after discard", int'(ack), 1);
      bus_stop();
      read_back(7'h30, 2, "R4 discarded byte");

      // R7 address wrap and R8 continued read
      page_write(7'h7C, 4, 11);
      page_write(7'h00, 2, 140);
      read_back(7'h7E, 4, "R7 wrap 7F to 00");
      bus_start();
      write_byte(8'hA1, ack);
      chk("R8 current read ack", int'(ack), 1);
      read_byte(b, 1'b0);
      chk("R8 continues at next address", int'(b), int'(model[7'h02]));
      bus_stop();

      chk("R9 drive steady while clock high", viol, 0);
      done = 1'b1;
      report();
   end
endmodule